// File: doc/BRIEF.md
# Dual-Port Same-Address Contention Arbiter

This block watches two independent memory ports, left and right, and flags the moment both select the same word. Each port brings an active-low select, an address and an active-low write strobe. When the two selected addresses coincide, the block picks a winner by arrival order: the port whose select and address were steady for longer keeps going. The other port sees its active-low busy flag pulled low, and its writes are blocked inside the block. The direction of either access plays no part in this decision.

The block runs on a single clock. The busy flags, the inhibits and the gated write enables are combinational from the current port inputs and a small amount of registered history. The history records when each port's access began and which port won the conflict that is in progress. A mode input changes the block into a follower. In that mode it makes no decision of its own, and each port's externally supplied busy level does nothing except block that port's writes. The gated write enables go to the storage array, which sits outside this block.

Top module: `dp_contend_arb`

## Requirements
- R1: A conflict exists only when both selects are low and the two addresses are equal. In every other case both busy outputs are high.
- R2: The write strobes play no part in arbitration. Read/write combinations that are otherwise identical produce the same busy outputs.
- R3: In the leading mode, the port whose current select-and-address began in an earlier cycle wins. The other port's busy goes low in the same cycle the match appears.
- R4: The two busy outputs are never low together.
- R5: In the leading mode, a port whose busy is low has its inhibit high and its gated write enable low, even with its strobe low. The busy input levels have no effect in this mode.
- R6: In the follower mode (`follower_mode` = 1) both busy outputs stay high. A port's inhibit equals the inverse of its busy input: low input blocks that port's writes, high input lets them pass.
- R7: Busy is released in the same cycle the addresses stop matching or either select goes high.
- R8: When both ports begin matching accesses in the same cycle, the left port wins and the right port is busied.
- R9: Once a winner is chosen, it holds for as long as the conflict lasts. This includes the case where both ports move to a new common address in the same cycle.
- R10: While reset is high both busy outputs are high and no winner is held. Accesses that are present when reset is released count as beginning in the first cycle after reset.
- R11: A port's gated write enable is high exactly when its select is low, its strobe is low and its inhibit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| follower_mode | input | 1 | 1 = follower (busy inputs gate writes), 0 = leading (block arbitrates) |
| l_sel_n | input | 1 | Left port select, active low |
| l_addr | input | ADDR_W | Left port word address |
| l_wstb_n | input | 1 | Left port write strobe, active low |
| r_sel_n | input | 1 | Right port select, active low |
| r_addr | input | ADDR_W | Right port word address |
| r_wstb_n | input | 1 | Right port write strobe, active low |
| l_busy_in_n | input | 1 | External left busy level, used in follower mode |
| r_busy_in_n | input | 1 | External right busy level, used in follower mode |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_busy_n | output | 1 | Right busy flag, active low |
| l_wr_inhibit | output | 1 | Left write blocked |
| r_wr_inhibit | output | 1 | Right write blocked |
| l_wr_go | output | 1 | Gated left write enable to storage |
| r_wr_go | output | 1 | Gated right write enable to storage |

## Verification
The bench builds the block with its default 11-bit address. This lets directed cases use the extreme words 0 and 2047, which shows that the whole address is compared. The random phase narrows the addresses to four words so that matches, partial matches, simultaneous starts and address moves during a conflict all occur often. The reference model records each port's access start as a cycle number. Because of this, arrival-order and hold decisions are checked against elapsed time rather than against per-cycle change flags.

// File: rtl/dp_arb_pkg.sv
package dp_arb_pkg;

    typedef enum logic [1:0] {
        WIN_NONE  = 2'd0,
        WIN_LEFT  = 2'd1,
        WIN_RIGHT = 2'd2
    } win_e;

    localparam int NUM_PORTS = 2;
    localparam int P_LEFT    = 0;
    localparam int P_RIGHT   = 1;

    typedef struct packed {
        logic sel;    // port selected this cycle
        logic fresh;  // access began this cycle
        logic wr;     // selected with write strobe active
    } port_stat_t;

    // Older access wins; equal age goes to the left port.
    function automatic win_e pick_winner(input logic l_fresh, input logic r_fresh);
        if (l_fresh && !r_fresh)
            return WIN_RIGHT;
        return WIN_LEFT;
    endfunction

endpackage

// File: rtl/dp_port_track.sv
module dp_port_track
    import dp_arb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wstb_n,
    output port_stat_t        stat
);
    logic              prev_sel;
    logic [ADDR_W-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sel  <= 1'b0;
            prev_addr <= '0;
        end else begin
            prev_sel  <= ~sel_n;
            prev_addr <= addr;
        end
    end

    always_comb begin
        stat.sel   = ~sel_n;
        stat.fresh = ~sel_n & (~prev_sel | (prev_addr != addr));
        stat.wr    = ~sel_n & ~wstb_n;
    end
endmodule

// File: rtl/dp_winner_sel.sv
module dp_winner_sel
    import dp_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic conflict,
    input  logic l_fresh,
    input  logic r_fresh,
    output win_e win_now
);
    win_e win_q;

    always_comb begin
        if (!conflict)
            win_now = WIN_NONE;
        else if (win_q != WIN_NONE)
            win_now = win_q;
        else
            win_now = pick_winner(l_fresh, r_fresh);
    end

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= WIN_NONE;
        else
            win_q <= win_now;
    end
endmodule

// File: rtl/dp_wr_gate.sv
module dp_wr_gate
    import dp_arb_pkg::*;
(
    input  logic       follower_mode,
    input  logic       busy_int,
    input  logic       busy_in_n,
    input  port_stat_t stat,
    output logic       inhibit,
    output logic       wr_go
);
    always_comb begin
        inhibit = follower_mode ? ~busy_in_n : busy_int;
        wr_go   = stat.wr & ~inhibit;
    end
endmodule

// File: rtl/dp_contend_arb.sv
module dp_contend_arb
    import dp_arb_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              follower_mode,
    input  logic              l_sel_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_wstb_n,
    input  logic              r_sel_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_wstb_n,
    input  logic              l_busy_in_n,
    input  logic              r_busy_in_n,
    output logic              l_busy_n,
    output logic              r_busy_n,
    output logic              l_wr_inhibit,
    output logic              r_wr_inhibit,
    output logic              l_wr_go,
    output logic              r_wr_go
);
    logic [NUM_PORTS-1:0]             sel_n_v;
    logic [NUM_PORTS-1:0]             wstb_n_v;
    logic [NUM_PORTS-1:0]             busy_in_n_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             busy_int;
    logic [NUM_PORTS-1:0]             inhibit_v;
    logic [NUM_PORTS-1:0]             go_v;
    port_stat_t                       stat [NUM_PORTS];
    logic                             conflict;
    win_e                             win_now;

    assign sel_n_v     = {r_sel_n, l_sel_n};
    assign wstb_n_v    = {r_wstb_n, l_wstb_n};
    assign busy_in_n_v = {r_busy_in_n, l_busy_in_n};
    assign addr_v      = {r_addr, l_addr};

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dp_port_track #(.ADDR_W(ADDR_W)) u_track (
            .clk    (clk),
            .rst    (rst),
            .sel_n  (sel_n_v[p]),
            .addr   (addr_v[p]),
            .wstb_n (wstb_n_v[p]),
            .stat   (stat[p])
        );

        dp_wr_gate u_gate (
            .follower_mode (follower_mode),
            .busy_int      (busy_int[p]),
            .busy_in_n     (busy_in_n_v[p]),
            .stat          (stat[p]),
            .inhibit       (inhibit_v[p]),
            .wr_go         (go_v[p])
        );
    end

    // Arbitration uses select and address only; write strobes are not looked at.
    assign conflict = ~rst & ~follower_mode
                    & stat[P_LEFT].sel & stat[P_RIGHT].sel
                    & (addr_v[P_LEFT] == addr_v[P_RIGHT]);

    dp_winner_sel u_win (
        .clk      (clk),
        .rst      (rst),
        .conflict (conflict),
        .l_fresh  (stat[P_LEFT].fresh),
        .r_fresh  (stat[P_RIGHT].fresh),
        .win_now  (win_now)
    );

    assign busy_int[P_LEFT]  = (win_now == WIN_RIGHT);
    assign busy_int[P_RIGHT] = (win_now == WIN_LEFT);

    assign l_busy_n     = ~busy_int[P_LEFT];
    assign r_busy_n     = ~busy_int[P_RIGHT];
    assign l_wr_inhibit = inhibit_v[P_LEFT];
    assign r_wr_inhibit = inhibit_v[P_RIGHT];
    assign l_wr_go      = go_v[P_LEFT];
    assign r_wr_go      = go_v[P_RIGHT];
endmodule

// File: rtl/dp_arb_chk.sv
module dp_arb_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              follower_mode,
    input logic              l_sel_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              r_sel_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              l_busy_in_n,
    input logic              r_busy_in_n,
    input logic              l_busy_n,
    input logic              r_busy_n,
    input logic              l_wr_inhibit,
    input logic              r_wr_inhibit,
    input logic              l_wr_go,
    input logic              r_wr_go
);
    logic match;
    assign match = !l_sel_n && !r_sel_n && (l_addr == r_addr);

    // R4
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!l_busy_n && !r_busy_n));

    // R1
    busy_needs_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_busy_n || !r_busy_n) |-> match);

    // R5
    l_busy_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        !l_busy_n |-> (l_wr_inhibit && !l_wr_go));

    // R5
    r_busy_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
        !r_busy_n |-> (r_wr_inhibit && !r_wr_go));

    // R6
    follower_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        follower_mode |-> (l_busy_n && r_busy_n
                           && (l_wr_inhibit == !l_busy_in_n)
                           && (r_wr_inhibit == !r_busy_in_n)));

    // R9
    winner_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (match && !follower_mode && $past(!r_busy_n)) |-> !r_busy_n);

    // R10
    reset_idle_chk: assert property (@(posedge clk)
        rst |-> (l_busy_n && r_busy_n));
endmodule

bind dp_contend_arb dp_arb_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .follower_mode (follower_mode),
    .l_sel_n       (l_sel_n),
    .l_addr        (l_addr),
    .r_sel_n       (r_sel_n),
    .r_addr        (r_addr),
    .l_busy_in_n   (l_busy_in_n),
    .r_busy_in_n   (r_busy_in_n),
    .l_busy_n      (l_busy_n),
    .r_busy_n      (r_busy_n),
    .l_wr_inhibit  (l_wr_inhibit),
    .r_wr_inhibit  (r_wr_inhibit),
    .l_wr_go       (l_wr_go),
    .r_wr_go       (r_wr_go)
);

// File: tb/tb_dp_contend_arb.sv
module tb_dp_contend_arb;
    localparam int AW = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic follower_mode = 1'b0;
    logic l_sel_n = 1'b1, r_sel_n = 1'b1, l_wstb_n = 1'b1, r_wstb_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic l_busy_n, r_busy_n, l_wr_inhibit, r_wr_inhibit, l_wr_go, r_wr_go;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    string tag = "R10";
    bit done = 1'b0;

    // reference model state
    int l_start = 0, r_start = 0;
    bit l_prev = 1'b0, r_prev = 1'b0;
    logic [AW-1:0] l_prev_a = '0, r_prev_a = '0;
    int win = 0;             // 0 none, 1 left, 2 right
    int exp_win, ls_now, rs_now;

    always #10 clk = ~clk;   // 50 MHz

    dp_contend_arb #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .follower_mode(follower_mode),
        .l_sel_n(l_sel_n), .l_addr(l_addr), .l_wstb_n(l_wstb_n),
        .r_sel_n(r_sel_n), .r_addr(r_addr), .r_wstb_n(r_wstb_n),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_inhibit(l_wr_inhibit), .r_wr_inhibit(r_wr_inhibit),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go));

    task automatic cmp(input string what, input logic act, input logic exp);
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, cyc, act, exp);
        end
    endtask

    // Compare against the model in the middle of the low clock phase.
    always @(negedge clk) begin
        bit conflict;
        logic e_lb, e_rb, e_li, e_ri;
        #5;
        ls_now = (!l_sel_n && (!l_prev || l_addr != l_prev_a)) ? cyc : l_start;
        rs_now = (!r_sel_n && (!r_prev || r_addr != r_prev_a)) ? cyc : r_start;
        conflict = !rst && !follower_mode && !l_sel_n && !r_sel_n && (l_addr == r_addr);
        if (!conflict)      exp_win = 0;
        else if (win != 0)  exp_win = win;
        else                exp_win = (ls_now <= rs_now) ? 1 : 2;
        e_lb = !(exp_win == 2);
        e_rb = !(exp_win == 1);
        e_li = follower_mode ? !l_busy_in_n : !e_lb;
        e_ri = follower_mode ? !r_busy_in_n : !e_rb;
        vectors++;
        cmp("l_busy_n", l_busy_n, e_lb);
        cmp("r_busy_n", r_busy_n, e_rb);
        cmp("l_wr_inhibit", l_wr_inhibit, e_li);
        cmp("r_wr_inhibit", r_wr_inhibit, e_ri);
        // R11 gated write enables
        cmp("l_wr_go", l_wr_go, !l_sel_n && !l_wstb_n && !e_li);
        cmp("r_wr_go", r_wr_go, !r_sel_n && !r_wstb_n && !e_ri);
    end

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            win = 0; l_prev = 0; r_prev = 0; l_prev_a = '0; r_prev_a = '0;
        end else begin
            win = exp_win; l_start = ls_now; r_start = rs_now;
            l_prev = !l_sel_n; r_prev = !r_sel_n; l_prev_a = l_addr; r_prev_a = r_addr;
        end
    end

    task automatic drive(input string t, input logic ls, input int la, input logic lw,
                         input logic rs, input int ra, input logic rw);
        @(negedge clk);
        tag = t;
        l_sel_n = ls; l_addr = AW'(la); l_wstb_n = lw;
        r_sel_n = rs; r_addr = AW'(ra); r_wstb_n = rw;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            finish_run();
        end
    end

    initial begin
        // R10: both ports matching while in reset; busy stays high
        drive("R10", 0, 12, 1, 0, 12, 1);
        drive("R10", 0, 12, 1, 0, 12, 1);
        @(negedge clk); rst = 1'b0;       // R10: both count as new -> left wins
        drive("R10", 0, 12, 1, 0, 12, 0);
        drive("R7", 1, 12, 1, 1, 12, 1);
        // R1: different addresses, then same address one side idle
        drive("R1", 0, 0, 0, 0, 2047, 0);
        drive("R1", 0, 2047, 0, 0, 2046, 0);
        drive("R1", 0, 2047, 0, 1, 2047, 0);
        // R3: left first, right arrives later -> right busy, its write gated (R5)
        drive("R3", 0, 2047, 1, 1, 0, 1);
        drive("R3", 0, 2047, 1, 0, 2047, 0);
        drive("R5", 0, 2047, 0, 0, 2047, 0);
        // R7: release on address mismatch
        drive("R7", 0, 2047, 0, 0, 2046, 0);
        drive("R7", 1, 0, 1, 1, 0, 1);
        // R3/R2: right first (reading), left later (writing) -> left busy
        drive("R2", 1, 0, 1, 0, 0, 1);
        drive("R2", 0, 0, 0, 0, 0, 1);
        drive("R2", 0, 0, 1, 0, 0, 0);
        // R5: busy input levels ignored in leading mode
        @(negedge clk); l_busy_in_n = 1'b0; r_busy_in_n = 1'b0; tag = "R5";
        drive("R5", 0, 0, 0, 0, 0, 0);
        @(negedge clk); l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        // R7: release when an enable goes high
        drive("R7", 0, 0, 0, 1, 0, 0);
        drive("R7", 1, 0, 1, 1, 0, 1);
        // R8: simultaneous start -> left wins
        drive("R8", 0, 100, 0, 0, 100, 0);
        drive("R8", 0, 100, 1, 0, 100, 1);
        drive("R8", 1, 0, 1, 1, 0, 1);
        // R9: right older wins, then both jump to a new common address together
        drive("R9", 1, 0, 1, 0, 7, 1);
        drive("R9", 0, 7, 1, 0, 7, 1);
        drive("R9", 0, 9, 0, 0, 9, 0);
        drive("R9", 0, 9, 1, 0, 9, 0);
        drive("R9", 0, 9, 0, 0, 9, 1);
        drive("R9", 1, 0, 1, 1, 0, 1);
        // R6: follower mode, matching accesses, busy inputs gate writes
        @(negedge clk); follower_mode = 1'b1; tag = "R6";
        drive("R6", 0, 5, 0, 0, 5, 0);
        @(negedge clk); l_busy_in_n = 1'b0; tag = "R6";
        @(negedge clk); r_busy_in_n = 1'b0; l_busy_in_n = 1'b1; tag = "R6";
        @(negedge clk); r_busy_in_n = 1'b1; tag = "R6";
        drive("R6", 1, 0, 1, 1, 0, 1);
        @(negedge clk); follower_mode = 1'b0;
        // Random leading-mode traffic over four words
        for (int i = 0; i < 3000; i++) begin
            drive(((i % 3) == 0) ? "R3" : (((i % 3) == 1) ? "R4" : "R9"),
                  1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)), 1'($urandom),
                  1'($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)), 1'($urandom));
        end
        // Random follower-mode traffic
        drive("R6", 1, 0, 1, 1, 0, 1);
        @(negedge clk); follower_mode = 1'b1;
        for (int i = 0; i < 500; i++) begin
            drive("R6", 1'($urandom), int'($urandom_range(0, 1)), 1'($urandom),
                  1'($urandom), int'($urandom_range(0, 1)), 1'($urandom));
            l_busy_in_n = 1'($urandom); r_busy_in_n = 1'($urandom);
        end
        // R10: reset in the middle of a conflict
        @(negedge clk); follower_mode = 1'b0; l_busy_in_n = 1'b1; r_busy_in_n = 1'b1;
        drive("R10", 1, 0, 1, 0, 3, 1);
        drive("R10", 0, 3, 1, 0, 3, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        drive("R10", 0, 3, 1, 0, 3, 1);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule